// File: doc/BRIEF.md
# Read/Write Grouping Bank Scheduler

This block keeps a small request queue for every DRAM bank and picks which queued request a bank should serve next. Requests are grouped by direction: one mode flag, shared by all banks, says whether reads or writes are currently being served. This cuts the number of data-bus turnarounds. Within the active direction, a request that hits the bank's open row is preferred over a miss. Among requests of equal rank, the oldest one wins.

The surrounding controller pushes requests through the enqueue port. It supplies the open-row state of every bank and polls one bank at a time. One cycle after a poll, the block reports the DRAM command the chosen request needs and that request's queue position. A column command (read or write) removes the request from its queue. An activate or precharge leaves the request queued, so it is picked again once its row is open. A read that would overtake an older write to the same row and column is held back by forcing write mode. Command timing is left to the caller.

Top module: `rw_group_sched`

## Requirements
- R1: A poll of a bank whose queue is empty returns command NOP (code 0) with no dequeue, and leaves the mode flag unchanged.
- R2: When the block is in write mode and no write is queued in any bank, it switches to read mode before choosing.
- R3: When the block is in read mode and no read is queued in any bank, it switches to write mode before choosing.
- R4: In read mode the choice is the oldest read whose row equals the polled bank's open row. Only if there is none is it the oldest read of any row. Queue index 0 is the oldest entry.
- R5: In write mode the choice is the oldest write that hits the open row. Only if there is none is it the oldest write of any row.
- R6: A read has a hazard when a write with the same row and column sits ahead of it in the same queue. A chosen read with a hazard is not served: the mode becomes write (rd_mode=0) and a write is chosen instead. A write in the same row but a different column causes no hazard.
- R7: A row hit is reported as RD (code 3) or WR (code 4) with res_deq=1 and is removed from the queue. A miss stays queued and is reported as ACT (code 1) when the bank has no open row, or as PRE (code 2) when another row is open.
- R8: When the polled bank holds nothing for the current mode, the mode flips once and the other direction is chosen. rd_mode shows the mode that was used.
- R9: Every poll produces exactly one result, with res_valid high on the cycle after the poll. No result appears without a poll.
- R10: enq_ready is low while the target bank's queue holds DEPTH entries, and a request offered then is dropped.
- R11: After reset all queues are empty, res_valid is low, enq_ready is high and the block is in read mode (rd_mode=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Offer a request |
| enq_write | input | 1 | 1 = write, 0 = read |
| enq_bank | input | $clog2(NBANK) | Target bank |
| enq_row | input | ROW_W | Row address |
| enq_col | input | COL_W | Column address |
| enq_ready | output | 1 | Target bank queue has room |
| poll_valid | input | 1 | Ask for a decision |
| poll_bank | input | $clog2(NBANK) | Bank being polled |
| open_valid | input | NBANK | Per-bank row-open flag |
| open_row | input | NBANK*ROW_W | Per-bank open row, bank b at bits b*ROW_W |
| res_valid | output | 1 | Decision valid |
| res_cmd | output | 3 | 0 NOP, 1 ACT, 2 PRE, 3 RD, 4 WR |
| res_idx | output | $clog2(DEPTH) | Queue position of the chosen request |
| res_deq | output | 1 | Chosen request was removed |
| rd_mode | output | 1 | Mode flag after the decision, 1 = read |

## Verification
The assertions assume the caller holds poll_bank and enq_bank inside the bank range, and changes open_valid and open_row only between polls. The bench drives open-row state from its own model of what the controller would have opened. It changes that state only while no poll is in flight, and it polls one bank at a time with idle cycles in between. No request is offered to a bank in the same cycle that the bank is polled, so the corner case of a simultaneous dequeue and enqueue stays out of the checked scenarios.

// File: rtl/rw_group_sched.sv
module rw_group_sched #(
  parameter int NBANK = 4,
  parameter int DEPTH = 4,
  parameter int ROW_W = 8,
  parameter int COL_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enq_valid,
  input  logic                     enq_write,
  input  logic [$clog2(NBANK)-1:0] enq_bank,
  input  logic [ROW_W-1:0]         enq_row,
  input  logic [COL_W-1:0]         enq_col,
  output logic                     enq_ready,
  input  logic                     poll_valid,
  input  logic [$clog2(NBANK)-1:0] poll_bank,
  input  logic [NBANK-1:0]         open_valid,
  input  logic [NBANK*ROW_W-1:0]   open_row,
  output logic                     res_valid,
  output logic [2:0]               res_cmd,
  output logic [$clog2(DEPTH)-1:0] res_idx,
  output logic                     res_deq,
  output logic                     rd_mode
);
  localparam int BW = $clog2(NBANK);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_PRE = 3'd2, C_RD = 3'd3, C_WR = 3'd4;

  typedef struct packed {
    logic             w;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
  } ent_t;

  ent_t          q   [NBANK][DEPTH];
  logic [CW-1:0] cnt [NBANK];

  logic any_rd, any_wr;
  always_comb begin
    any_rd = 1'b0;
    any_wr = 1'b0;
    for (int b = 0; b < NBANK; b++)
      for (int i = 0; i < DEPTH; i++)
        if (CW'(i) < cnt[b]) begin
          if (q[b][i].w) any_wr = 1'b1;
          else           any_rd = 1'b1;
        end
  end

  logic [ROW_W-1:0] orow;
  logic             ov, sel_empty;
  logic [DEPTH-1:0] v, w, hit, haz;
  assign orow      = open_row[int'(poll_bank)*ROW_W +: ROW_W];
  assign ov        = open_valid[poll_bank];
  assign sel_empty = (cnt[poll_bank] == '0);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      v[i]   = CW'(i) < cnt[poll_bank];
      w[i]   = q[poll_bank][i].w;
      hit[i] = ov && (q[poll_bank][i].row == orow);
      haz[i] = 1'b0;
      for (int j = 0; j < DEPTH; j++)
        if (j < i && CW'(j) < cnt[poll_bank] && q[poll_bank][j].w &&
            q[poll_bank][j].row == q[poll_bank][i].row &&
            q[poll_bank][j].col == q[poll_bank][i].col)
          haz[i] = 1'b1;
    end
  end

  function automatic logic [IW:0] oldest(input logic [DEPTH-1:0] m);
    oldest = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (m[i]) oldest = {1'b1, IW'(i)};
  endfunction

  logic [IW:0] rdh, rda, wrh, wra;
  assign rdh = oldest(v & ~w & hit);
  assign rda = oldest(v & ~w);
  assign wrh = oldest(v & w & hit);
  assign wra = oldest(v & w);

  logic          r_ok, r_hit, w_ok, w_hit;
  logic [IW-1:0] r_idx, w_idx;
  assign r_hit = rdh[IW];
  assign r_idx = r_hit ? rdh[IW-1:0] : rda[IW-1:0];
  assign r_ok  = r_hit ? !haz[rdh[IW-1:0]] : (rda[IW] && !haz[rda[IW-1:0]]);
  assign w_hit = wrh[IW];
  assign w_idx = w_hit ? wrh[IW-1:0] : wra[IW-1:0];
  assign w_ok  = wra[IW];

  logic [2:0]    sel_cmd;
  logic [IW-1:0] sel_idx;
  logic          sel_deq, sel_mode, m0, use_rd, use_wr;
  always_comb begin
    sel_cmd  = C_NOP;
    sel_idx  = '0;
    sel_deq  = 1'b0;
    sel_mode = rd_mode;
    m0       = rd_mode ? any_rd : !any_wr;
    use_rd   = 1'b0;
    use_wr   = 1'b0;
    if (!sel_empty) begin
      if (m0) begin
        if (r_ok) use_rd = 1'b1;
        else      use_wr = w_ok;
      end else begin
        if (w_ok) use_wr = 1'b1;
        else      use_rd = r_ok;
      end
      if (use_rd) begin
        sel_mode = 1'b1;
        sel_idx  = r_idx;
        sel_deq  = r_hit;
        sel_cmd  = r_hit ? C_RD : (ov ? C_PRE : C_ACT);
      end else if (use_wr) begin
        sel_mode = 1'b0;
        sel_idx  = w_idx;
        sel_deq  = w_hit;
        sel_cmd  = w_hit ? C_WR : (ov ? C_PRE : C_ACT);
      end else begin
        sel_mode = !m0;
      end
    end
  end

  assign enq_ready = (cnt[enq_bank] != CW'(DEPTH));

  logic [NBANK-1:0] deq_b, enq_b;
  logic [CW-1:0]    wpos [NBANK];
  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      deq_b[b] = poll_valid && sel_deq && (poll_bank == BW'(b));
      enq_b[b] = enq_valid && enq_ready && (enq_bank == BW'(b));
      wpos[b]  = cnt[b] - CW'(deq_b[b]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_mode   <= 1'b1;
      res_valid <= 1'b0;
      res_cmd   <= C_NOP;
      res_idx   <= '0;
      res_deq   <= 1'b0;
      for (int b = 0; b < NBANK; b++) begin
        cnt[b] <= '0;
        for (int i = 0; i < DEPTH; i++) q[b][i] <= '0;
      end
    end else begin
      res_valid <= poll_valid;
      if (poll_valid) begin
        res_cmd <= sel_cmd;
        res_idx <= sel_idx;
        res_deq <= sel_deq;
        rd_mode <= sel_mode;
      end
      for (int b = 0; b < NBANK; b++) begin
        for (int i = 0; i < DEPTH - 1; i++)
          if (deq_b[b] && IW'(i) >= sel_idx) q[b][i] <= q[b][i+1];
        if (enq_b[b]) q[b][wpos[b][IW-1:0]] <= '{w: enq_write, row: enq_row, col: enq_col};
        cnt[b] <= cnt[b] + CW'(enq_b[b]) - CW'(deq_b[b]);
      end
    end
  end
endmodule

// File: rtl/rw_group_sched_chk.sv
module rw_group_sched_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       poll_valid,
  input logic       sel_empty,
  input logic       res_valid,
  input logic [2:0] res_cmd,
  input logic       res_deq,
  input logic       rd_mode
);
  AST_POLL_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n) poll_valid |=> res_valid); // R9
  AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rst_n) !poll_valid |=> !res_valid); // R9
  AST_EMPTY_NOP: assert property (@(posedge clk) disable iff (!rst_n) poll_valid && sel_empty |=> res_cmd == 3'd0 && !res_deq); // R1
  AST_EMPTY_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n) poll_valid && sel_empty |=> $stable(rd_mode)); // R1
  AST_IDLE_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n) !poll_valid |=> $stable(rd_mode)); // R2
  AST_RD_IN_READ_MODE: assert property (@(posedge clk) disable iff (!rst_n) res_valid && res_cmd == 3'd3 |-> rd_mode); // R4
  AST_WR_IN_WRITE_MODE: assert property (@(posedge clk) disable iff (!rst_n) res_valid && res_cmd == 3'd4 |-> !rd_mode); // R5
  AST_DEQ_ONLY_COLUMN: assert property (@(posedge clk) disable iff (!rst_n) res_valid && res_deq |-> res_cmd == 3'd3 || res_cmd == 3'd4); // R7
  AST_MISS_STAYS: assert property (@(posedge clk) disable iff (!rst_n) res_valid && (res_cmd == 3'd1 || res_cmd == 3'd2) |-> !res_deq); // R7
endmodule

bind rw_group_sched rw_group_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .poll_valid(poll_valid), .sel_empty(sel_empty),
  .res_valid(res_valid), .res_cmd(res_cmd), .res_deq(res_deq), .rd_mode(rd_mode)
);

// File: tb/sim_rw_group_sched.sv
module sim_rw_group_sched;
  logic        clk = 0, rst_n = 0;
  logic        enq_valid = 0, enq_write = 0;
  logic [1:0]  enq_bank = 0;
  logic [7:0]  enq_row = 0;
  logic [5:0]  enq_col = 0;
  logic        enq_ready;
  logic        poll_valid = 0;
  logic [1:0]  poll_bank = 0;
  logic [3:0]  open_valid = 0;
  logic [31:0] open_row = 0;
  logic        res_valid, res_deq, rd_mode;
  logic [2:0]  res_cmd;
  logic [1:0]  res_idx;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [2:0] cmd;
    logic [1:0] idx;
    logic       deq;
    logic       mode;
    string      tag;
  } exp_t;
  exp_t exp_q[$];
  exp_t e;

  always #4 clk = ~clk;

  rw_group_sched u0 (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_write(enq_write),
    .enq_bank(enq_bank), .enq_row(enq_row), .enq_col(enq_col), .enq_ready(enq_ready),
    .poll_valid(poll_valid), .poll_bank(poll_bank), .open_valid(open_valid),
    .open_row(open_row), .res_valid(res_valid), .res_cmd(res_cmd), .res_idx(res_idx),
    .res_deq(res_deq), .rd_mode(rd_mode)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R9 result without poll", 1, 0);
      end else begin
        e = exp_q.pop_front();
        n_tests++;
        if (res_cmd !== e.cmd || res_deq !== e.deq || rd_mode !== e.mode ||
            (e.cmd != 3'd0 && res_idx !== e.idx)) begin
          n_fail++;
          $display("FAIL %s actual cmd=%0d idx=%0d deq=%0d mode=%0d expected cmd=%0d idx=%0d deq=%0d mode=%0d",
                   e.tag, res_cmd, res_idx, res_deq, rd_mode, e.cmd, e.idx, e.deq, e.mode);
        end
      end
    end
  end

  task automatic enq(input bit wr, input int b, input int row, input int col, input bit rdy, input string tag);
    @(negedge clk);
    enq_valid = 1; enq_write = wr; enq_bank = 2'(b); enq_row = 8'(row); enq_col = 6'(col);
    #1 check(enq_ready === rdy, tag, int'(enq_ready), int'(rdy));
    @(negedge clk);
    enq_valid = 0;
  endtask

  task automatic poll(input int b, input int cmd, input int idx, input bit deq, input bit mode, input string tag);
    exp_t x;
    @(negedge clk);
    x.cmd = 3'(cmd); x.idx = 2'(idx); x.deq = deq; x.mode = mode; x.tag = tag;
    exp_q.push_back(x);
    poll_valid = 1; poll_bank = 2'(b);
    @(negedge clk);
    poll_valid = 0;
  endtask

  task automatic set_open(input int b, input bit valid, input int row);
    open_valid[b] = valid;
    open_row[b*8 +: 8] = 8'(row);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(res_valid === 0, "R11 res_valid after reset", int'(res_valid), 0);
    check(rd_mode === 1, "R11 read mode after reset", int'(rd_mode), 1);
    check(enq_ready === 1, "R11 enq_ready after reset", int'(enq_ready), 1);

    poll(0, 0, 0, 0, 1, "R1 empty bank gives NOP");

    enq(0, 0, 5, 1, 1, "R11 enqueue accepted");
    poll(0, 1, 0, 0, 1, "R7 read miss on closed bank gives ACT");
    set_open(0, 1, 5);
    poll(0, 3, 0, 1, 1, "R7 read hit gives RD and dequeues");

    set_open(1, 1, 3);
    enq(0, 1, 7, 0, 1, "R4 enqueue");
    enq(0, 1, 3, 2, 1, "R4 enqueue");
    enq(0, 1, 3, 4, 1, "R4 enqueue");
    poll(1, 3, 1, 1, 1, "R4 oldest read hit before older miss");
    poll(1, 3, 1, 1, 1, "R4 next read hit");
    poll(1, 2, 0, 0, 1, "R7 miss with other row open gives PRE");
    set_open(1, 1, 7);
    poll(1, 3, 0, 1, 1, "R7 miss stayed queued");

    set_open(2, 1, 4);
    enq(1, 2, 2, 0, 1, "R3 enqueue");
    enq(1, 2, 4, 1, 1, "R3 enqueue");
    poll(2, 4, 1, 1, 0, "R3 no reads anywhere so write hit served");
    poll(2, 2, 0, 0, 0, "R5 write miss gives PRE");
    set_open(2, 1, 2);
    poll(2, 4, 0, 1, 0, "R5 write hit");
    poll(0, 0, 0, 0, 0, "R1 empty keeps write mode");

    enq(0, 3, 1, 0, 1, "R2 enqueue");
    poll(3, 1, 0, 0, 1, "R2 no writes so read mode");
    set_open(3, 1, 1);
    poll(3, 3, 0, 1, 1, "R2 read hit");

    enq(1, 0, 5, 3, 1, "R6 enqueue");
    enq(0, 0, 5, 3, 1, "R6 enqueue");
    poll(0, 4, 0, 1, 0, "R6 hazard forces write");
    poll(0, 3, 0, 1, 1, "R6 read served after write");
    enq(1, 0, 5, 2, 1, "R6 enqueue");
    enq(0, 0, 5, 3, 1, "R6 enqueue");
    poll(0, 3, 1, 1, 1, "R6 other column no hazard");
    poll(0, 4, 0, 1, 0, "R3 write after reads drained");

    enq(1, 1, 9, 0, 1, "R8 enqueue");
    enq(0, 2, 7, 1, 1, "R8 enqueue");
    poll(2, 2, 0, 0, 1, "R8 no writes in bank flips to read");
    poll(1, 2, 0, 0, 0, "R8 no reads in bank flips to write");
    set_open(1, 1, 9);
    poll(1, 4, 0, 1, 0, "R8 write hit");
    set_open(2, 1, 7);
    poll(2, 3, 0, 1, 1, "R2 read hit");

    for (int c = 0; c < 4; c++) enq(0, 3, 1, c, 1, "R10 fill");
    enq(0, 3, 1, 7, 0, "R10 full refuses");
    poll(3, 3, 0, 1, 1, "R10 drain");
    poll(3, 3, 0, 1, 1, "R10 drain");
    poll(3, 3, 0, 1, 1, "R10 drain");
    poll(3, 3, 0, 1, 1, "R10 drain");
    poll(3, 0, 0, 0, 1, "R10 refused entry absent");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 every poll answered", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      check(0, "watchdog expired", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule